// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave

This block is the target side of a two-wire serial bus, placed in front of a small byte-wide memory. The bus clock and data lines are sampled on the system clock. The block pulls the data line low through an output enable, and the bus pull-up returns the line high when the enable is off. The block watches for start and stop conditions. It decodes the address byte that follows a start and answers only when the address carries the fixed device-type nibble and the three strap pins.

In a write, the master sends two word-address bytes and then any number of data bytes. Each data byte is stored and the internal pointer moves to the next location. In a read, the block streams bytes from the internal pointer for as long as the master acknowledges. A random read is done by writing only the two address bytes and then issuing a repeated start with the read bit set. The memory has 2^MEM_AW bytes, with MEM_AW between 9 and 16; the default is 1 KiB.

Top module: `twi_mem_slave`

## Requirements
- R1: Both bus lines pass through SYNC_STAGES flip-flops before use. The output enable changes only on the cycle after a detected SCL falling edge, or when it is released by a start or a stop. The enable never changes while SCL is high.
- R2: A start (SDA falling while SCL is high) aborts any operation in progress, even partway through a byte. A byte that was not completed is not stored. The block then waits for an address byte.
- R3: A stop (SDA rising while SCL is high) returns the block to idle. In idle, bytes clocked without a preceding start get no acknowledge.
- R4: The address byte matches only when bits 7:4 equal 4'b1010 and bits 3:1 equal sel_i. Bit 0 is 1 for a read and 0 for a write. On a mismatch the block stays silent, including during later bytes, until the next start.
- R5: The block acknowledges a matched address byte and every byte it receives in a write. It does this by driving SDA low during the ninth SCL clock.
- R6: After a write address, the next two bytes form the word address, high byte first. Only the low MEM_AW bits are used; higher bits of the high byte are ignored.
- R7: Each later write byte is stored at the pointer, and then the pointer increments. The pointer wraps from 2^MEM_AW-1 to 0.
- R8: A read sends bytes MSB first, starting at the pointer. The pointer increments after each byte and wraps the same way as in a write.
- R9: If the master acknowledges a read byte, the next byte follows. If the master does not acknowledge, the block releases SDA and stays silent until a start or a stop.
- R10: A read starts at the pointer left by the last write or read. This includes a write of only the word address followed by a repeated start.
- R11: After reset the output enable is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (resolved wired-AND) |
| sel_i | input | 3 | Strap pins compared with address bits 3:1 |
| sda_oe_o | output | 1 | When high, the data line is pulled low |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it makes a start or a stop. They also assume that each SCL high and low phase lasts longer than the synchronizer delay, so the two lines never appear to move in the same system cycle. The bench keeps within these limits. Every bus phase is a quarter-bit of eight system clocks, and SDA is changed two clocks after SCL has gone low. Starts and stops are made only with SCL held high for a full quarter-bit. The bench uses the same timing for the deliberate aborts partway through a byte.

// File: rtl/twi_slave_pkg.sv
package twi_slave_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_DATA,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_HUSH
   } twi_st_e;

   localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   logic prev_q;
   logic level;

   if (STAGES < 1) begin : g_bad_stages
      $error("twi_line_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) s_q <= 1'b1;
         else         s_q <= line_i;
      end
      assign level = s_q;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '1;
         else         chain_q <= {chain_q[STAGES-2:0], line_i};
      end
      assign level = chain_q[STAGES-1];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= level;
   end

   assign level_o = level;
   assign rise_o  = level & ~prev_q;
   assign fall_o  = ~level & prev_q;

endmodule

// File: rtl/twi_byte_ram.sv
module twi_byte_ram #(
   parameter int AW = 10
) (
   input  logic          clk_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [7:0]    wdata_i,
   output logic [7:0]    rdata_o
);

   localparam int DEPTH = 1 << AW;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) cells[addr_i] <= wdata_i;
      rdata_o <= cells[addr_i];
   end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
   import twi_slave_pkg::*;
#(
   parameter int         MEM_AW      = 10,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] TYPE_CODE   = DEV_TYPE_CODE
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] sel_i,
   output logic       sda_oe_o
);

   localparam int HI_W = MEM_AW - 8;

   if (MEM_AW < 9 || MEM_AW > 16) begin : g_bad_aw
      $error("twi_mem_slave: MEM_AW must lie in 9..16");
   end

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;

   twi_line_sync #(.STAGES(SYNC_STAGES)) i_scl_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i),
      .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
   );

   twi_line_sync #(.STAGES(SYNC_STAGES)) i_sda_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i),
      .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
   );

   logic start_det, stop_det;
   assign start_det = sda_fall & scl_lvl;
   assign stop_det  = sda_rise & scl_lvl;

   twi_st_e           st_q, after_q;
   logic [3:0]        bit_cnt;
   logic [7:0]        rx_sh, tx_sh;
   logic [HI_W-1:0]   addr_hi;
   logic [MEM_AW-1:0] waddr;
   logic              oe_q;
   logic [7:0]        rdata;
   logic              mem_we;
   logic              byte_full;
   logic              dev_hit;

   assign byte_full = (bit_cnt == 4'd8);
   assign dev_hit   = (rx_sh[7:4] == TYPE_CODE) && (rx_sh[3:1] == sel_i);
   assign mem_we    = (st_q == ST_DATA) && scl_fall && byte_full
                      && !start_det && !stop_det;

   twi_byte_ram #(.AW(MEM_AW)) i_ram (
      .clk_i(clk_i), .we_i(mem_we), .addr_i(waddr),
      .wdata_i(rx_sh), .rdata_o(rdata)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_IDLE;
         after_q <= ST_IDLE;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         addr_hi <= '0;
         waddr   <= '0;
         oe_q    <= 1'b0;
      end else if (start_det) begin
         st_q    <= ST_DEV;
         bit_cnt <= '0;
         oe_q    <= 1'b0;
      end else if (stop_det) begin
         st_q    <= ST_IDLE;
         bit_cnt <= '0;
         oe_q    <= 1'b0;
      end else begin
         case (st_q)
            ST_DEV, ST_AHI, ST_ALO, ST_DATA: begin
               if (scl_rise && !byte_full) begin
                  rx_sh   <= {rx_sh[6:0], sda_lvl};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (scl_fall && byte_full) begin
                  bit_cnt <= '0;
                  case (st_q)
                     ST_DEV: begin
                        if (dev_hit) begin
                           oe_q    <= 1'b1;
                           st_q    <= ST_ACK;
                           after_q <= rx_sh[0] ? ST_TX : ST_AHI;
                        end else begin
                           st_q <= ST_HUSH;
                        end
                     end
                     ST_AHI: begin
                        addr_hi <= rx_sh[HI_W-1:0];
                        oe_q    <= 1'b1;
                        st_q    <= ST_ACK;
                        after_q <= ST_ALO;
                     end
                     ST_ALO: begin
                        waddr   <= {addr_hi, rx_sh};
                        oe_q    <= 1'b1;
                        st_q    <= ST_ACK;
                        after_q <= ST_DATA;
                     end
                     default: begin
                        waddr   <= waddr + 1'b1;
                        oe_q    <= 1'b1;
                        st_q    <= ST_ACK;
                        after_q <= ST_DATA;
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  st_q    <= after_q;
                  bit_cnt <= '0;
                  if (after_q == ST_TX) begin
                     oe_q  <= ~rdata[7];
                     tx_sh <= rdata;
                  end else begin
                     oe_q <= 1'b0;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bit_cnt == 4'd7) begin
                     oe_q    <= 1'b0;
                     st_q    <= ST_MACK;
                     bit_cnt <= '0;
                  end else begin
                     oe_q    <= ~tx_sh[6];
                     tx_sh   <= {tx_sh[6:0], 1'b0};
                     bit_cnt <= bit_cnt + 4'd1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  waddr <= waddr + 1'b1;
                  if (sda_lvl) st_q    <= ST_HUSH;
                  else         bit_cnt <= 4'd1;
               end else if (scl_fall && bit_cnt == 4'd1) begin
                  st_q    <= ST_TX;
                  bit_cnt <= '0;
                  oe_q    <= ~rdata[7];
                  tx_sh   <= rdata;
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = oe_q;

   // R1
   oe_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(oe_q) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

   // R2
   start_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_det |=> (st_q == ST_DEV && !oe_q && bit_cnt == 4'd0));

   // R3
   stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_det |=> (st_q == ST_IDLE && !oe_q));

   // R4
   silent_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_HUSH || st_q == ST_IDLE) |-> !oe_q);

   // R5
   drive_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_q |-> (st_q == ST_ACK || st_q == ST_TX));

   // R7
   ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_we && waddr == {MEM_AW{1'b1}}) |=> (waddr == '0));

endmodule

// File: tb/test_twi_mem_slave.sv
module test_twi_mem_slave;

   localparam int AW = 10;
   localparam int Q  = 8;
   localparam logic [2:0] SEL = 3'b101;
   localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
   localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   wire  sda_line = sda_m & ~sda_oe;

   always #2.5 clk = ~clk;

   twi_mem_slave #(.MEM_AW(AW)) i_twi_mem_slave (
      .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sel_i(SEL), .sda_oe_o(sda_oe)
   );

   int checks = 0;
   int errors = 0;
   int viol   = 0;
   logic [7:0] model [1 << AW];
   int ptr = 0;
   logic [7:0] exp_q [$];
   logic [7:0] obs;
   event got_ev;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(got_ev) begin
      logic [7:0] e;
      if (exp_q.size() == 0) begin
         check(1'b0, "R8 unexpected byte", obs, 0);
      end else begin
         e = exp_q.pop_front();
         check(obs == e, "R8/R10 read data", obs, e);
      end
   end

   // R1 monitor: enable must not move while SCL is held high
   logic prev_scl = 1'b1, prev_oe = 1'b0;
   always @(negedge clk) begin
      if (rst_n && scl_m && prev_scl && sda_oe != prev_oe) viol++;
      prev_scl <= scl_m;
      prev_oe  <= sda_oe;
   end

   task automatic wq(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_bit(input logic v, output logic s);
      scl_m = 1'b0; wq(2); sda_m = v; wq(Q);
      scl_m = 1'b1; wq(Q);
      @(negedge clk); s = sda_line;
      wq(Q);
   endtask

   task automatic bus_start();
      scl_m = 1'b0; wq(2); sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      scl_m = 1'b0; wq(2); sda_m = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
      bus_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic mack);
      logic s;
      logic [7:0] b = '0;
      for (int i = 0; i < 8; i++) begin
         bus_bit(1'b1, s);
         b = {b[6:0], s};
      end
      bus_bit(~mack, s);
      obs = b;
      -> got_ev;
      wq(1);
   endtask

   task automatic send_ack(input logic [7:0] b, input string tag);
      logic a;
      send_byte(b, a);
      check(a == 1'b1, tag, a, 1);
   endtask

   task automatic write_seq(input int addr, input logic [7:0] hi_extra, input logic [7:0] d [$]);
      bus_start();
      send_ack(DEV_W, "R4/R5 write address ack");
      send_ack(hi_extra | 8'((addr >> 8) & 8'h03), "R5/R6 high address ack");
      send_ack(8'(addr & 8'hFF), "R5/R6 low address ack");
      ptr = addr;
      foreach (d[i]) begin
         send_ack(d[i], "R5/R7 data ack");
         model[ptr] = d[i];
         ptr = (ptr + 1) % (1 << AW);
      end
   endtask

   task automatic read_cur(input int n);
      bus_start();
      send_ack(DEV_R, "R4/R5 read address ack");
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(model[ptr]);
         ptr = (ptr + 1) % (1 << AW);
         recv_byte(i != n - 1);
      end
   endtask

   task automatic run_tests();
      logic a, s;
      logic [7:0] d [$];
      wq(4);
      // R11 reset state
      check(sda_oe == 1'b0, "R11 enable low in reset", sda_oe, 0);
      rst_n = 1'b1;
      wq(4);
      check(sda_oe == 1'b0, "R11 enable low after reset", sda_oe, 0);
      // R11/R3: no start yet, a matching byte is ignored
      send_byte(DEV_W, a);
      check(a == 1'b0, "R3 idle ignores byte without start", a, 0);

      // R4: wrong type nibble, then silent for later bytes
      bus_start();
      send_byte({4'b0010, SEL, 1'b0}, a);
      check(a == 1'b0, "R4 type mismatch no ack", a, 0);
      send_byte(8'h00, a);
      check(a == 1'b0, "R4 silent after mismatch", a, 0);
      // R4: wrong strap bits (repeated start)
      bus_start();
      send_byte({4'b1010, 3'b010, 1'b0}, a);
      check(a == 1'b0, "R4 select mismatch no ack", a, 0);
      bus_stop();

      // R6: upper bits of high address byte ignored
      d = '{8'h11, 8'h22, 8'h33};
      write_seq(12'h123, 8'hFC, d);
      bus_stop();

      // R10 random read via address-only write and repeated start
      d = '{};
      write_seq(12'h123, 8'h00, d);
      read_cur(3);
      bus_stop();

      // R7/R8 wrap on write and read
      d = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
      write_seq(12'h3FE, 8'h00, d);
      bus_stop();
      d = '{};
      write_seq(12'h3FF, 8'h00, d);
      read_cur(2);
      bus_stop();
      // R10 current-address read continues at 0x001
      read_cur(1);
      // R9 after master nack the line stays released
      for (int i = 0; i < 9; i++) begin
         bus_bit(1'b1, s);
         check(s == 1'b1, "R9 released after nack", s, 1);
      end
      bus_stop();

      // R2 start aborts a partial write byte
      d = '{8'h5A, 8'h66};
      write_seq(12'h050, 8'h00, d);
      bus_stop();
      d = '{8'hC3};
      write_seq(12'h050, 8'h00, d);
      for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
      read_cur(1);   // R2: expects the old 0x66 at 0x051
      bus_stop();

      // R3 stop aborts, then bytes without start get no ack
      bus_start();
      send_ack(DEV_W, "R3 address ack before abort");
      for (int i = 0; i < 4; i++) bus_bit(1'b1, s);
      bus_stop();
      send_byte(DEV_R, a);
      check(a == 1'b0, "R3 no ack after stop without start", a, 0);
      bus_start();
      bus_stop();

      wq(20);
      check(exp_q.size() == 0, "R8 all reads observed", exp_q.size(), 0);
      check(viol == 0, "R1 enable stable while SCL high", viol, 0);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            check(1'b0, "watchdog expired", 0, 1);
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule